// File: doc/BRIEF.md
# Real-Mode Interrupt Vector Dispatcher

This block delivers one interrupt or exception while the core runs in real-address mode. A start pulse carries a vector number, a flag that marks the request as an external interrupt, the vector table base and limit, and a snapshot of the core's FLAGS, CS, IP, SS and SP along with its halt state. The block first checks that the four-byte table entry lies inside the limit. If it does not, the block raises a general-protection fault request with an error code and makes no memory access. If the entry fits, the block saves the return frame on the stack and then fetches the handler address.

Memory traffic uses a single word-wide port with a req/ack handshake and at most one access outstanding. The block writes three words to the stack and then reads two words from the table. Once the reads are done it hands the core a CS load, followed by the new IP, the new SP and the flags with the single-step, interrupt-enable, alignment-check and resume bits cleared. A halted core woken by an external interrupt resumes after its halt instruction. Each delivery carries a fixed charge of work units, which the core adds to its cycle accounting.

Top module: `rmi_dispatch`

## Requirements
- R1: The table index is vector × 4. When index + 3 is greater than the limit, the block pulses `fault` with `fault_code` = index + 2, makes no memory access, and does not pulse `done`.
- R2: When index + 3 equals the limit, delivery proceeds normally.
- R3: For an external request (`ext_irq`=1) while `halted`=1, the block pushes IP + 1 (16-bit wrap) and pulses `halt_clear` once. Otherwise it pushes IP unchanged and leaves `halt_clear` low.
- R4: Three word writes occur in this order: FLAGS bits 15:0, then CS, then IP. Before each write SP is decremented by 2 with 16-bit wrap, and the write address is SS × 16 + SP. While `mem_req` waits for `mem_ack`, the address is held steady.
- R5: At `done`, `new_sp` equals the entry SP − 6 (16-bit wrap).
- R6: At `done`, `new_flags` equals the entry FLAGS with bits 8, 9, 16 and 18 cleared and every other bit kept. `trap_cancel` pulses together with `done`.
- R7: After the pushes, the block reads the new IP from base + index and then the new CS from base + index + 2. A delivery makes exactly five memory accesses.
- R8: `cs_load` pulses one cycle before `done`, with `new_cs` and `new_cs_base` = new CS × 16 valid.
- R9: `done` is a single-cycle pulse that comes with `new_ip` and `charge` = 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a delivery (sampled when idle) |
| vector | input | VEC_W | Interrupt vector number |
| ext_irq | input | 1 | Request is an external interrupt |
| halted | input | 1 | Core is in the halt state |
| tbl_base | input | ADDR_W | Vector table base address |
| tbl_limit | input | LIM_W | Vector table limit |
| cur_flags | input | FLAG_W | Current FLAGS |
| cur_cs | input | 16 | Current CS |
| cur_ip | input | 16 | Current IP |
| cur_ss | input | 16 | Current SS |
| cur_sp | input | 16 | Current SP |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 16 | Read data, valid with ack |
| halt_clear | output | 1 | Pulse: leave the halt state |
| cs_load | output | 1 | Pulse: load CS and CS base |
| new_cs | output | 16 | New CS value |
| new_cs_base | output | ADDR_W | New CS × 16 |
| done | output | 1 | Pulse: commit IP, SP and FLAGS |
| new_ip | output | 16 | New IP |
| new_sp | output | 16 | New SP |
| new_flags | output | FLAG_W | FLAGS after clearing |
| trap_cancel | output | 1 | Pulse: drop a pending single-step trap |
| charge | output | COST_W | Work units for this delivery |
| fault | output | 1 | Pulse: general-protection fault request |
| fault_code | output | VEC_W+2 | Fault error code |

## Verification
The bench probes the limit compare from both sides. With index + 3 exactly equal to the limit, delivery must go ahead. A design that uses greater-or-equal would fault there instead, and one that forgets the +3 would deliver one entry past the limit. Stack pushes are checked against an SP that wraps from 0x0002 through 0x0000 to 0xFFFE, which catches an address that does not wrap SP in 16 bits or that decrements after the write. The halt rule is run with an IP of 0xFFFF and with a non-external request, so an unconditional increment or a missing wrap in the pushed IP shows up in the frame.

// File: rtl/rmi_pkg.sv
package rmi_pkg;

    localparam int WORD_W = 16;

    // Flag bit positions cleared on delivery
    localparam int TF_BIT = 8;
    localparam int IF_BIT = 9;
    localparam int RF_BIT = 16;
    localparam int AC_BIT = 18;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH_FL,
        ST_PUSH_CS,
        ST_PUSH_IP,
        ST_RD_IP,
        ST_RD_CS,
        ST_LOAD_CS,
        ST_FINISH,
        ST_FAULT
    } state_t;

endpackage

// File: rtl/rmi_limit_chk.sv
module rmi_limit_chk #(
    parameter int VEC_W = 8,
    parameter int LIM_W = 16
) (
    input  logic [VEC_W-1:0] vector,
    input  logic [LIM_W-1:0] limit,
    output logic [VEC_W+1:0] index,
    output logic             over,
    output logic [VEC_W+1:0] code
);
    localparam int IDX_W = VEC_W + 2;
    localparam int CW    = ((IDX_W > LIM_W) ? IDX_W : LIM_W) + 1;

    logic [CW-1:0] last_byte;

    always_comb begin
        index     = {vector, 2'b00};
        last_byte = CW'(index) + CW'(3);
        over      = last_byte > CW'(limit);
        // low two bits of index are zero, so the add cannot carry out
        code      = index + IDX_W'(2);
    end
endmodule

// File: rtl/rmi_flag_mask.sv
module rmi_flag_mask #(
    parameter int                FLAG_W   = 32,
    parameter logic [FLAG_W-1:0] CLR_MASK = '0
) (
    input  logic [FLAG_W-1:0] flags_in,
    output logic [FLAG_W-1:0] flags_out
);
    for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
        if (CLR_MASK[i]) begin : g_clr
            assign flags_out[i] = 1'b0;
        end else begin : g_keep
            assign flags_out[i] = flags_in[i];
        end
    end
endmodule

// File: rtl/rmi_addr_gen.sv
module rmi_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10
) (
    input  logic [15:0]       seg_ss,
    input  logic [15:0]       sp_next,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [IDX_W-1:0]  tbl_index,
    input  logic              tbl_hi,
    output logic [ADDR_W-1:0] stack_addr,
    output logic [ADDR_W-1:0] table_addr
);
    always_comb begin
        stack_addr = ADDR_W'({seg_ss, 4'h0}) + ADDR_W'(sp_next);
        table_addr = tbl_base + ADDR_W'(tbl_index) + (tbl_hi ? ADDR_W'(2) : ADDR_W'(0));
    end
endmodule

// File: rtl/rmi_dispatch.sv
module rmi_dispatch #(
    parameter int ADDR_W = 32,
    parameter int VEC_W  = 8,
    parameter int LIM_W  = 16,
    parameter int FLAG_W = 32,
    parameter int COST   = 20,
    parameter int COST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VEC_W-1:0]  vector,
    input  logic              ext_irq,
    input  logic              halted,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [LIM_W-1:0]  tbl_limit,
    input  logic [FLAG_W-1:0] cur_flags,
    input  logic [15:0]       cur_cs,
    input  logic [15:0]       cur_ip,
    input  logic [15:0]       cur_ss,
    input  logic [15:0]       cur_sp,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [15:0]       mem_rdata,
    output logic              halt_clear,
    output logic              cs_load,
    output logic [15:0]       new_cs,
    output logic [ADDR_W-1:0] new_cs_base,
    output logic              done,
    output logic [15:0]       new_ip,
    output logic [15:0]       new_sp,
    output logic [FLAG_W-1:0] new_flags,
    output logic              trap_cancel,
    output logic [COST_W-1:0] charge,
    output logic              fault,
    output logic [VEC_W+1:0]  fault_code
);
    import rmi_pkg::*;

    localparam int IDX_W = VEC_W + 2;
    localparam logic [FLAG_W-1:0] CLR_MASK =
        (FLAG_W'(1) << TF_BIT) | (FLAG_W'(1) << IF_BIT) |
        (FLAG_W'(1) << RF_BIT) | (FLAG_W'(1) << AC_BIT);

    typedef struct packed {
        state_t            state;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] base;
        logic [FLAG_W-1:0] flags;
        logic [15:0]       cs;
        logic [15:0]       ip;
        logic [15:0]       ss;
        logic [15:0]       sp;
        logic [15:0]       hnd_ip;
        logic [15:0]       hnd_cs;
        logic              halt_clr;
        logic [IDX_W-1:0]  fcode;
    } regs_t;

    localparam regs_t RST_VAL = '{state: ST_IDLE, default: '0};

    regs_t r_q, r_d;

    // Sub-block wiring
    logic [IDX_W-1:0]  chk_index;
    logic              chk_over;
    logic [IDX_W-1:0]  chk_code;
    logic [15:0]       sp_dec;
    logic              tbl_hi;
    logic              use_tbl;
    logic [ADDR_W-1:0] stack_addr;
    logic [ADDR_W-1:0] table_addr;

    rmi_limit_chk #(
        .VEC_W (VEC_W),
        .LIM_W (LIM_W)
    ) u_limit (
        .vector (vector),
        .limit  (tbl_limit),
        .index  (chk_index),
        .over   (chk_over),
        .code   (chk_code)
    );

    rmi_addr_gen #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_addr (
        .seg_ss     (r_q.ss),
        .sp_next    (sp_dec),
        .tbl_base   (r_q.base),
        .tbl_index  (r_q.idx),
        .tbl_hi     (tbl_hi),
        .stack_addr (stack_addr),
        .table_addr (table_addr)
    );

    rmi_flag_mask #(
        .FLAG_W   (FLAG_W),
        .CLR_MASK (CLR_MASK)
    ) u_mask (
        .flags_in  (r_q.flags),
        .flags_out (new_flags)
    );

    assign sp_dec = r_q.sp - 16'd2;

    always_comb begin
        r_d        = r_q;
        r_d.halt_clr = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_wdata  = '0;
        tbl_hi     = 1'b0;
        use_tbl    = 1'b0;

        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.idx = chk_index;
                    if (chk_over) begin
                        r_d.fcode = chk_code;
                        r_d.state = ST_FAULT;
                    end else begin
                        r_d.base     = tbl_base;
                        r_d.flags    = cur_flags;
                        r_d.cs       = cur_cs;
                        r_d.ss       = cur_ss;
                        r_d.sp       = cur_sp;
                        r_d.halt_clr = ext_irq & halted;
                        r_d.ip       = cur_ip + ((ext_irq & halted) ? 16'd1 : 16'd0);
                        r_d.state    = ST_PUSH_FL;
                    end
                end
            end
            ST_PUSH_FL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = r_q.flags[15:0];
                if (mem_ack) begin
                    r_d.sp    = sp_dec;
                    r_d.state = ST_PUSH_CS;
                end
            end
            ST_PUSH_CS: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = r_q.cs;
                if (mem_ack) begin
                    r_d.sp    = sp_dec;
                    r_d.state = ST_PUSH_IP;
                end
            end
            ST_PUSH_IP: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = r_q.ip;
                if (mem_ack) begin
                    r_d.sp    = sp_dec;
                    r_d.state = ST_RD_IP;
                end
            end
            ST_RD_IP: begin
                mem_req = 1'b1;
                use_tbl = 1'b1;
                if (mem_ack) begin
                    r_d.hnd_ip = mem_rdata;
                    r_d.state  = ST_RD_CS;
                end
            end
            ST_RD_CS: begin
                mem_req = 1'b1;
                use_tbl = 1'b1;
                tbl_hi  = 1'b1;
                if (mem_ack) begin
                    r_d.hnd_cs = mem_rdata;
                    r_d.state  = ST_LOAD_CS;
                end
            end
            ST_LOAD_CS: r_d.state = ST_FINISH;
            ST_FINISH:  r_d.state = ST_IDLE;
            ST_FAULT:   r_d.state = ST_IDLE;
            default:    r_d.state = ST_IDLE;
        endcase

        mem_addr = use_tbl ? table_addr : stack_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= RST_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign halt_clear  = r_q.halt_clr;
    assign cs_load     = (r_q.state == ST_LOAD_CS);
    assign new_cs      = r_q.hnd_cs;
    assign new_cs_base = ADDR_W'({r_q.hnd_cs, 4'h0});
    assign done        = (r_q.state == ST_FINISH);
    assign trap_cancel = done;
    assign new_ip      = r_q.hnd_ip;
    assign new_sp      = r_q.sp;
    assign charge      = done ? COST_W'(COST) : '0;
    assign fault       = (r_q.state == ST_FAULT);
    assign fault_code  = r_q.fcode;

endmodule

// File: rtl/rmi_dispatch_chk.sv
module rmi_dispatch_chk #(
    parameter int ADDR_W = 32,
    parameter int FLAG_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              done,
    input logic              fault,
    input logic              cs_load,
    input logic [FLAG_W-1:0] new_flags
);
    localparam logic [FLAG_W-1:0] CLR =
        (FLAG_W'(1) << 8) | (FLAG_W'(1) << 9) | (FLAG_W'(1) << 16) | (FLAG_W'(1) << 18);

    // R1
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!mem_req && !done));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    cs_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(cs_load));

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((new_flags & CLR) == '0));
endmodule

bind rmi_dispatch rmi_dispatch_chk #(
    .ADDR_W (ADDR_W),
    .FLAG_W (FLAG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .done      (done),
    .fault     (fault),
    .cs_load   (cs_load),
    .new_flags (new_flags)
);

// File: tb/rmi_dispatch_test.sv
module rmi_dispatch_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  vector = '0;
    logic        ext_irq = 1'b0;
    logic        halted = 1'b0;
    logic [31:0] tbl_base = '0;
    logic [15:0] tbl_limit = '0;
    logic [31:0] cur_flags = '0;
    logic [15:0] cur_cs = '0, cur_ip = '0, cur_ss = '0, cur_sp = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        halt_clear, cs_load, done, trap_cancel, fault;
    logic [15:0] new_cs, new_ip, new_sp;
    logic [31:0] new_cs_base, new_flags;
    logic [7:0]  charge;
    logic [9:0]  fault_code;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int txn_cnt = 0;
    bit cs_seen = 0;
    bit hc_seen = 0;

    typedef struct { logic [31:0] addr; logic [15:0] data; } wr_t;
    wr_t exp_q[$];
    logic [15:0] mem [int unsigned];

    always #10 clk = ~clk;

    rmi_dispatch uut (
        .clk(clk), .rst_n(rst_n), .start(start), .vector(vector), .ext_irq(ext_irq),
        .halted(halted), .tbl_base(tbl_base), .tbl_limit(tbl_limit), .cur_flags(cur_flags),
        .cur_cs(cur_cs), .cur_ip(cur_ip), .cur_ss(cur_ss), .cur_sp(cur_sp),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .halt_clear(halt_clear), .cs_load(cs_load),
        .new_cs(new_cs), .new_cs_base(new_cs_base), .done(done), .new_ip(new_ip),
        .new_sp(new_sp), .new_flags(new_flags), .trap_cancel(trap_cancel), .charge(charge),
        .fault(fault), .fault_code(fault_code)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory model: one-cycle ack latency
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else begin
            mem_ack   <= mem_req && !mem_ack;
            mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 16'hDEAD;
        end
    end

    // Monitor: scoreboard for stack writes, event capture
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req && mem_ack) begin
                txn_cnt++;
                if (mem_we) begin
                    if (exp_q.size() == 0) begin
                        check(0, "R4 unexpected write", mem_addr, 32'hFFFF_FFFF);
                    end else begin
                        wr_t e;
                        e = exp_q.pop_front();
                        check(mem_addr == e.addr, "R4 push address", mem_addr, e.addr);
                        check(mem_wdata == e.data, "R4 push data", {16'h0, mem_wdata}, {16'h0, e.data});
                    end
                end
            end
            if (cs_load) cs_seen = 1;
            if (halt_clear) hc_seen = 1;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic deliver(input logic [7:0] v, input bit e, input bit h, input logic [31:0] fl,
                           input logic [15:0] cs, input logic [15:0] ip, input logic [15:0] ss,
                           input logic [15:0] sp, input logic [31:0] base, input logic [15:0] lim,
                           input logic [15:0] nip, input logic [15:0] ncs);
        int idx;
        bit over;
        logic [15:0] s;
        logic [15:0] pip;
        int wait_n;
        idx  = int'(v) * 4;
        over = (idx + 3) > int'(lim);
        pip  = (e && h) ? ip + 16'd1 : ip;
        mem[base + idx]     = nip;
        mem[base + idx + 2] = ncs;
        if (!over) begin
            s = sp - 16'd2; exp_q.push_back('{ {12'h0, ss, 4'h0} + {16'h0, s}, fl[15:0] });
            s = s  - 16'd2; exp_q.push_back('{ {12'h0, ss, 4'h0} + {16'h0, s}, cs });
            s = s  - 16'd2; exp_q.push_back('{ {12'h0, ss, 4'h0} + {16'h0, s}, pip });
        end
        txn_cnt = 0; cs_seen = 0; hc_seen = 0;
        @(negedge clk);
        vector = v; ext_irq = e; halted = h; cur_flags = fl; cur_cs = cs; cur_ip = ip;
        cur_ss = ss; cur_sp = sp; tbl_base = base; tbl_limit = lim; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_n = 0;
        while (!done && !fault && wait_n < 100) begin
            @(negedge clk);
            wait_n++;
        end
        if (over) begin
            check(fault == 1'b1, "R1 fault raised", {31'h0, fault}, 32'h1);
            check(fault_code == 10'(idx + 2), "R1 fault code", {22'h0, fault_code}, idx + 2);
            check(txn_cnt == 0, "R1 no memory access", txn_cnt, 0);
            check(done == 1'b0, "R1 no done", {31'h0, done}, 32'h0);
        end else begin
            check(done == 1'b1, "R2 delivery done", {31'h0, done}, 32'h1);
            check(exp_q.size() == 0, "R4 three pushes", exp_q.size(), 0);
            check(txn_cnt == 5, "R7 access count", txn_cnt, 5);
            check(new_ip == nip, "R7 new IP", {16'h0, new_ip}, {16'h0, nip});
            check(new_cs == ncs, "R7 new CS", {16'h0, new_cs}, {16'h0, ncs});
            check(new_cs_base == {12'h0, ncs, 4'h0}, "R8 CS base", new_cs_base, {12'h0, ncs, 4'h0});
            check(cs_seen == 1, "R8 cs_load before done", {31'h0, cs_seen}, 32'h1);
            check(new_sp == sp - 16'd6, "R5 new SP", {16'h0, new_sp}, {16'h0, sp - 16'd6});
            check(new_flags == (fl & ~32'h0005_0300), "R6 flags cleared", new_flags, fl & ~32'h0005_0300);
            check(trap_cancel == 1'b1, "R6 trap cancel", {31'h0, trap_cancel}, 32'h1);
            check(charge == 8'd20, "R9 charge", {24'h0, charge}, 32'd20);
            check(hc_seen == (e && h), "R3 halt clear", {31'h0, hc_seen}, {31'h0, e && h});
            @(negedge clk);
            check(done == 1'b0, "R9 done one cycle", {31'h0, done}, 32'h0);
        end
        exp_q.delete();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(mem_req == 0 && done == 0 && fault == 0, "reset idle",
              {29'h0, mem_req, done, fault}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_req == 0 && done == 0 && fault == 0, "reset idle after release",
              {29'h0, mem_req, done, fault}, 32'h0);
        // R7 R4 R6 plain delivery
        deliver(8'h08, 0, 0, 32'h0007_0346, 16'h1234, 16'h0100, 16'h2000, 16'h1000,
                32'h0, 16'h03FF, 16'hABCD, 16'h5678);
        // R1 index past limit
        deliver(8'h40, 1, 0, 32'h0000_0202, 16'h1111, 16'h2222, 16'h3000, 16'h0800,
                32'h0, 16'h00FF, 16'h0, 16'h0);
        // R2 last entry exactly at limit, nonzero base
        deliver(8'h3F, 1, 0, 32'h0000_0200, 16'hF000, 16'h0042, 16'h0050, 16'h0400,
                32'h0000_1000, 16'h00FF, 16'h1357, 16'h2468);
        // R1 limit one short
        deliver(8'h3F, 0, 0, 32'h0, 16'h0, 16'h0, 16'h0, 16'h0100, 32'h0, 16'h00FE, 16'h0, 16'h0);
        // R3 halted external, IP wraps; R4 SP wraps
        deliver(8'h02, 1, 1, 32'h0004_0100, 16'h0700, 16'hFFFF, 16'h0000, 16'h0002,
                32'h0, 16'h03FF, 16'h0EEE, 16'hC000);
        // R3 halted but software request: no advance
        deliver(8'h21, 0, 1, 32'hFFFF_FFFF, 16'h0ABC, 16'h0500, 16'h9000, 16'hFFF0,
                32'h0000_0200, 16'h03FF, 16'h7777, 16'h8888);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule